// File: doc/BRIEF.md
# Key-Restart Watchdog Timer

This block is a watchdog peripheral with a 32-bit word-addressed register port. Software loads a reload value, sets the control register to start counting, and must keep writing one exact 32-bit key value to the restart register. Each key write reloads a down-counter. Any other value written there is dropped. The counter steps down once per tick. A control bit picks the tick period: a fast prescale or a slow prescale of the system clock.

When the count steps from one to zero, a sticky timeout flag is set. If reset generation is enabled, a reset pulse then runs for the number of system clocks held in the width register. During that pulse the block drives one of three reset targets, chosen by a two-bit scope field. The subsystem target is a vector gated by a per-subsystem mask. When the pulse ends, the run bit in the control register clears itself, so software that polls it can see that the expiry has finished. Loading a reload value of one and then writing the key gives an expiry on the very next tick.

Top module: `wdk_top`

Register word addresses: 0 live count (read only), 1 reload value, 2 restart key (write only, reads 0), 3 control, 4 timeout status (bit 0), 5 status clear (write only, reads 0), 6 pulse width, 7 subsystem mask. Control bits: 0 run, 1 reset enable, 4 fast tick, 6:5 scope (0 subsystem vector, 1 whole chip, 2 processor, 3 no output), 7 spare flag with no effect on timing. Bits 3:2 and 31:8 read 0.

## Requirements
- R1: After synchronous reset, count, reload, control and status read 0. Width reads 16. The mask reads 0x023FFFF3, which is bits 0 to 25 set except bits 2, 3, 22, 23 and 24. All reset outputs are low.
- R2: A write of exactly 0x00004755 to address 2 loads the count from the reload register on that clock edge. Address 0 reads back the live count.
- R3: A write of any other value to address 2, including 0x00014755, leaves the count unchanged. It neither reloads the count nor stops it.
- R4: While control bit 0 is set, the count drops by one every 4 clocks when bit 4 is set and every 12 clocks when bit 4 is clear. The period is timed from the most recent key write. While bit 0 is clear, the count holds.
- R5: A step of the count from 1 to 0 sets status bit 0. The bit stays set until a write to address 5 with bit 0 set. A write there with bit 0 clear has no effect.
- R6: With reload 1 and a key write, the first tick after the key write brings the count to 0 and raises the timeout.
- R7: If control bit 1 is set at expiry, the reset pulse starts on the next clock and lasts for the width value in clocks, or 1 clock if the width is 0. Control bit 0 reads 0 after the pulse. If bit 1 is clear, no pulse is driven and bit 0 stays set.
- R8: During a pulse, scope 0 drives sub_rst_o with the mask, scope 1 drives chip_rst_o, scope 2 drives cpu_rst_o, and scope 3 drives nothing. At most one kind of target is active at a time. Mask bits above 25 are dropped on write.
- R9: Control bits 0, 1, 4, 5, 6 and 7 read back as written. All other control bits read 0.
- R10: Once the count is 0, it stays at 0 and raises no further timeout until the next key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sub_rst_o | output | 26 | Per-subsystem reset pulse, gated by the mask |
| chip_rst_o | output | 1 | Whole-chip reset pulse |
| cpu_rst_o | output | 1 | Processor-only reset pulse |

## Verification
The counter is driven at both tick rates from several reload values: five at the fast rate, three at the slow rate, and ten with a bad key written part way through. These cases separate a correct prescale period from an off-by-one period, and a true key compare from a compare of the low 16 bits only. Expiry is tried with reset disabled and then with each of the four scopes at widths 3, 0 and 2. This shows whether the capture of scope and mask, the zero-width rule and the self-clearing run bit are each wired to the right target. A behavioural model in the bench predicts every register read and every reset output on every clock.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam logic [31:0] RESTART_KEY  = 32'h0000_4755;
    localparam logic [7:0]  CTRL_RW_MASK = 8'hF3;

    typedef enum logic [2:0] {
        A_COUNT    = 3'd0,
        A_RELOAD   = 3'd1,
        A_KICK     = 3'd2,
        A_CTRL     = 3'd3,
        A_STAT     = 3'd4,
        A_STAT_CLR = 3'd5,
        A_WIDTH    = 3'd6,
        A_MASK     = 3'd7
    } addr_e;

    typedef enum logic [1:0] {
        SC_SOC  = 2'd0,
        SC_CHIP = 2'd1,
        SC_CPU  = 2'd2,
        SC_NONE = 2'd3
    } scope_e;

    typedef struct packed {
        logic       boot2;
        scope_e     scope;
        logic       fast;
        logic [1:0] spare;
        logic       rst_en;
        logic       run;
    } ctrl_t;

    // Subsystems kept out of the default reset set: 2, 3, 22, 23, 24
    function automatic logic [31:0] default_mask(int unsigned n);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            v[i] = (i < n) && !(i == 2 || i == 3 || i == 22 || i == 23 || i == 24);
        end
        return v;
    endfunction

endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int unsigned FAST_DIV = 4,
    parameter int unsigned SLOW_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    input  logic restart,
    output logic tick
);
    localparam int unsigned MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int unsigned CW      = $clog2(MAX_DIV + 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_DIV - 1);

    logic [CW-1:0] pre_q;
    logic [CW-1:0] limit;

    assign limit = fast ? LIM_FAST : LIM_SLOW;
    assign tick  = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + CW'(1);
        end
    end

    // R4: ticks never fall on two adjacent clocks
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("tick on consecutive clocks");

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign count  = cnt_q;
    assign expire = tick && !load && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_expire_to_zero_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == '0))
        else $error("count not zero after expiry");

    p_zero_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !load) |=> (count == '0))
        else $error("count left zero without a reload");

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse
    import wdk_pkg::*;
#(
    parameter int unsigned NUM_SUB = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [31:0]        width,
    input  scope_e             scope,
    input  logic [NUM_SUB-1:0] mask,
    output logic [NUM_SUB-1:0] sub_rst,
    output logic               chip_rst,
    output logic               cpu_rst,
    output logic               done
);
    logic [31:0]        left_q;
    scope_e             sc_q;
    logic [NUM_SUB-1:0] msk_q;
    logic               active;

    assign active   = (left_q != '0);
    assign done     = (left_q == 32'd1);
    assign sub_rst  = (active && sc_q == SC_SOC) ? msk_q : '0;
    assign chip_rst = active && (sc_q == SC_CHIP);
    assign cpu_rst  = active && (sc_q == SC_CPU);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            sc_q   <= SC_SOC;
            msk_q  <= '0;
        end else if (fire && !active) begin
            left_q <= (width == '0) ? 32'd1 : width;
            sc_q   <= scope;
            msk_q  <= mask;
        end else if (active) begin
            left_q <= left_q - 32'd1;
        end
    end

    p_scope_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|sub_rst, chip_rst, cpu_rst}))
        else $error("more than one reset target active");

    p_fire_starts_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && !active) |=> active)
        else $error("pulse did not start after expiry");

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int unsigned NUM_SUB   = 26,
    parameter int unsigned FAST_DIV  = 4,
    parameter int unsigned SLOW_DIV  = 12,
    parameter int unsigned DEF_WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_SUB-1:0] sub_rst_o,
    output logic               chip_rst_o,
    output logic               cpu_rst_o
);
    localparam logic [31:0] MASK_INIT = default_mask(NUM_SUB);

    ctrl_t              ctrl_q;
    logic [31:0]        reload_q;
    logic [31:0]        width_q;
    logic [NUM_SUB-1:0] mask_q;
    logic               stat_q;

    addr_e       a;
    logic        key_ok;
    logic        bad_kick;
    logic        clr_hit;
    logic        tick;
    logic        expire;
    logic        pulse_done;
    logic [31:0] count;

    assign a        = addr_e'(bus_addr);
    assign key_ok   = bus_wr && (a == A_KICK) && (bus_wdata == RESTART_KEY);
    assign bad_kick = bus_wr && (a == A_KICK) && (bus_wdata != RESTART_KEY);
    assign clr_hit  = bus_wr && (a == A_STAT_CLR) && bus_wdata[0];

    wdk_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .fast(ctrl_q.fast),
        .restart(key_ok), .tick(tick)
    );

    wdk_counter #(.CNT_W(32)) u_cnt (
        .clk(clk), .rst(rst), .load(key_ok), .load_val(reload_q),
        .tick(tick), .count(count), .expire(expire)
    );

    wdk_pulse #(.NUM_SUB(NUM_SUB)) u_pulse (
        .clk(clk), .rst(rst), .fire(expire && ctrl_q.rst_en),
        .width(width_q), .scope(ctrl_q.scope), .mask(mask_q),
        .sub_rst(sub_rst_o), .chip_rst(chip_rst_o), .cpu_rst(cpu_rst_o),
        .done(pulse_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            width_q  <= 32'(DEF_WIDTH);
            mask_q   <= MASK_INIT[NUM_SUB-1:0];
        end else begin
            if (bus_wr) begin
                case (a)
                    A_RELOAD: reload_q <= bus_wdata;
                    A_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata[7:0] & CTRL_RW_MASK);
                    A_WIDTH:  width_q  <= bus_wdata;
                    A_MASK:   mask_q   <= bus_wdata[NUM_SUB-1:0];
                    default:  ;
                endcase
            end
            if (pulse_done) ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          stat_q <= 1'b0;
        else if (expire)  stat_q <= 1'b1;
        else if (clr_hit) stat_q <= 1'b0;
    end

    always_comb begin
        case (a)
            A_COUNT:  bus_rdata = count;
            A_RELOAD: bus_rdata = reload_q;
            A_CTRL:   bus_rdata = 32'(ctrl_q);
            A_STAT:   bus_rdata = 32'(stat_q);
            A_WIDTH:  bus_rdata = width_q;
            A_MASK:   bus_rdata = 32'(mask_q);
            default:  bus_rdata = '0;
        endcase
    end

    p_kick_loads_r2: assert property (@(posedge clk) disable iff (rst)
        key_ok |=> (count == $past(reload_q)))
        else $error("key write did not load count");

    p_bad_key_r3: assert property (@(posedge clk) disable iff (rst)
        (bad_kick && !tick) |=> (count == $past(count)))
        else $error("bad key changed count");

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr_hit) |=> stat_q)
        else $error("timeout flag dropped without clear");

    p_run_clears_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_done |=> !ctrl_q.run)
        else $error("run bit survived the end of the pulse");

endmodule

// File: tb/wdk_top_test.sv
module wdk_top_test;
    localparam int NSUB  = 26;
    localparam int FDIV  = 4;
    localparam int SDIV  = 12;
    localparam logic [31:0] KEY = 32'h0000_4755;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [2:0]      bus_addr = 3'd0;
    logic [31:0]     bus_wdata = 32'd0;
    logic [31:0]     bus_rdata;
    logic [NSUB-1:0] sub_rst_o;
    logic            chip_rst_o;
    logic            cpu_rst_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done_flag = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_cnt, m_reload, m_width, m_pulse;
    logic [7:0]  m_ctrl;
    logic [25:0] m_mask, m_pmask;
    logic [1:0]  m_scope;
    logic        m_stat;
    int          m_pre;

    wdk_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_rst_o(sub_rst_o),
        .chip_rst_o(chip_rst_o), .cpu_rst_o(cpu_rst_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        int    div;
        bit    run, key, tk, ex;
        logic [31:0] pold;
        if (rst) begin
            m_cnt = 0; m_reload = 0; m_width = 16; m_pulse = 0;
            m_ctrl = 0; m_mask = 26'h23FFFF3; m_pmask = 0; m_scope = 0;
            m_stat = 0; m_pre = 0;
        end else begin
            div  = m_ctrl[4] ? FDIV : SDIV;
            run  = m_ctrl[0];
            key  = bus_wr && bus_addr == 3'd2 && bus_wdata == KEY;
            tk   = run && (m_pre >= div - 1);
            ex   = 0;
            pold = m_pulse;
            if (key) m_cnt = m_reload;
            else if (tk && m_cnt != 0) begin
                if (m_cnt == 1) ex = 1;
                m_cnt = m_cnt - 1;
            end
            if (!run || key || tk) m_pre = 0;
            else m_pre = m_pre + 1;
            if (ex && m_ctrl[1] && pold == 0) begin
                m_pulse = (m_width == 0) ? 1 : m_width;
                m_scope = m_ctrl[6:5];
                m_pmask = m_mask;
            end else if (pold != 0) m_pulse = pold - 1;
            if (ex) m_stat = 1;
            else if (bus_wr && bus_addr == 3'd5 && bus_wdata[0]) m_stat = 0;
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: m_reload = bus_wdata;
                    3'd3: m_ctrl   = bus_wdata[7:0] & 8'hF3;
                    3'd6: m_width  = bus_wdata;
                    3'd7: m_mask   = bus_wdata[25:0];
                    default: ;
                endcase
            end
            if (pold == 1) m_ctrl[0] = 1'b0;
        end
    end

    function automatic logic [31:0] model_read(logic [2:0] ad);
        case (ad)
            3'd0: return m_cnt;
            3'd1: return m_reload;
            3'd3: return {24'd0, m_ctrl};
            3'd4: return {31'd0, m_stat};
            3'd6: return m_width;
            3'd7: return {6'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] er;
        logic [25:0] es;
        bit ec, ep;
        bit act_p;
        er = model_read(bus_addr);
        act_p = (m_pulse != 0);
        es = (act_p && m_scope == 2'd0) ? m_pmask : 26'd0;
        ec = act_p && m_scope == 2'd1;
        ep = act_p && m_scope == 2'd2;
        n_cmp++;
        if (bus_rdata !== er || sub_rst_o !== es || chip_rst_o !== ec || cpu_rst_o !== ep) begin
            n_bad++;
            $display("FAIL %s cycle model: rdata=%h/%h sub=%h/%h chip=%b/%b cpu=%b/%b (act/exp)",
                     cur_req, bus_rdata, er, sub_rst_o, es, chip_rst_o, ec, cpu_rst_o, ep);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(string req, logic [2:0] ad, logic [31:0] exp);
        bus_addr = ad;
        #1;
        chk(req, bus_rdata, exp);
        bus_addr = 3'd0;
        #1;
    endtask

    task automatic wr(logic [2:0] ad, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = ad; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(3);
        rst = 1'b0;
        step();
        // R1: reset values
        cur_req = "R1";
        rd("R1 count", 3'd0, 32'd0);
        rd("R1 reload", 3'd1, 32'd0);
        rd("R1 kick", 3'd2, 32'd0);
        rd("R1 ctrl", 3'd3, 32'd0);
        rd("R1 stat", 3'd4, 32'd0);
        rd("R1 clr", 3'd5, 32'd0);
        rd("R1 width", 3'd6, 32'd16);
        rd("R1 mask", 3'd7, 32'h023F_FFF3);
        chk("R1 outputs", {sub_rst_o, chip_rst_o, cpu_rst_o}, 32'd0);

        // R3 / R2: key compare
        cur_req = "R3";
        wr(3'd1, 32'd5);
        wr(3'd2, 32'h0000_4756);
        rd("R3 near key", 3'd0, 32'd0);
        wr(3'd2, 32'h0001_4755);
        rd("R3 upper bits", 3'd0, 32'd0);
        cur_req = "R2";
        wr(3'd2, KEY);
        rd("R2 reload", 3'd0, 32'd5);

        // R4 fast tick, R5/R6 expiry without reset, R10 hold
        cur_req = "R4";
        wr(3'd3, 32'h11);
        wr(3'd2, KEY);
        step(8);
        rd("R4 fast count", 3'd0, 32'd3);
        cur_req = "R5";
        step(12);
        rd("R5 expired count", 3'd0, 32'd0);
        rd("R5 status set", 3'd4, 32'd1);
        cur_req = "R10";
        step(20);
        rd("R10 zero holds", 3'd0, 32'd0);
        rd("R7 run kept without rst_en", 3'd3, 32'h11);
        chk("R7 no pulse", {sub_rst_o, chip_rst_o, cpu_rst_o}, 32'd0);
        cur_req = "R5";
        wr(3'd5, 32'd0);
        rd("R5 bit0 clear write ignored", 3'd4, 32'd1);
        wr(3'd5, 32'd1);
        rd("R5 cleared", 3'd4, 32'd0);

        // R4 slow tick and hold when stopped
        cur_req = "R4";
        wr(3'd3, 32'h01);
        wr(3'd1, 32'd3);
        wr(3'd2, KEY);
        step(12);
        rd("R4 slow count", 3'd0, 32'd2);
        wr(3'd3, 32'h00);
        step(30);
        rd("R4 stopped hold", 3'd0, 32'd2);

        // R9 control readback
        cur_req = "R9";
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R9 ctrl bits", 3'd3, 32'hF3);
        wr(3'd3, 32'h00);
        step(20);

        // R6/R7/R8 subsystem scope, width 3
        cur_req = "R8";
        wr(3'd6, 32'd3);
        wr(3'd7, 32'hFFFF_0F0F);
        rd("R8 mask truncated", 3'd7, 32'h03FF_0F0F);
        wr(3'd1, 32'd1);
        wr(3'd3, 32'h03);
        cur_req = "R6";
        wr(3'd2, KEY);
        step(11);
        rd("R6 before tick", 3'd0, 32'd1);
        chk("R7 no pulse yet", 32'(sub_rst_o), 32'd0);
        step();
        rd("R6 expired on first tick", 3'd0, 32'd0);
        cur_req = "R8";
        chk("R8 soc pulse", 32'(sub_rst_o), 32'h03FF_0F0F);
        chk("R8 chip idle", 32'(chip_rst_o), 32'd0);
        step(2);
        chk("R7 pulse held", 32'(sub_rst_o), 32'h03FF_0F0F);
        step();
        cur_req = "R7";
        chk("R7 pulse ended", 32'(sub_rst_o), 32'd0);
        rd("R7 run self-cleared", 3'd3, 32'h02);

        // scope chip, width 0
        cur_req = "R7";
        wr(3'd5, 32'd1);
        wr(3'd6, 32'd0);
        wr(3'd3, 32'h23);
        wr(3'd2, KEY);
        step(11);
        chk("R8 chip before", 32'(chip_rst_o), 32'd0);
        step();
        chk("R8 chip pulse", 32'(chip_rst_o), 32'd1);
        chk("R8 sub idle", 32'(sub_rst_o), 32'd0);
        step();
        chk("R7 zero width one clock", 32'(chip_rst_o), 32'd0);
        rd("R7 run cleared chip", 3'd3, 32'h22);

        // scope processor, fast, width 2
        cur_req = "R8";
        wr(3'd6, 32'd2);
        wr(3'd3, 32'h53);
        wr(3'd2, KEY);
        step(4);
        chk("R8 cpu pulse", 32'(cpu_rst_o), 32'd1);
        chk("R8 chip idle cpu", 32'(chip_rst_o), 32'd0);
        step(2);
        chk("R8 cpu ended", 32'(cpu_rst_o), 32'd0);
        rd("R7 run cleared cpu", 3'd3, 32'h52);

        // reserved scope
        wr(3'd3, 32'h73);
        wr(3'd2, KEY);
        step(4);
        chk("R8 reserved quiet", {sub_rst_o, chip_rst_o, cpu_rst_o}, 32'd0);
        rd("R5 status reserved", 3'd4, 32'd1);
        step(2);
        rd("R7 run cleared reserved", 3'd3, 32'h72);

        // R3 bad key while counting
        cur_req = "R3";
        wr(3'd3, 32'h11);
        wr(3'd1, 32'd10);
        wr(3'd2, KEY);
        step(5);
        wr(3'd2, 32'h0000_4754);
        rd("R3 bad key mid count", 3'd0, 32'd9);
        step(2);
        rd("R3 count kept running", 3'd0, 32'd8);
        wr(3'd3, 32'h00);
        step(4);
        finish_run();
    end
endmodule